// File: doc/BRIEF.md
# Ninth-Bit and Error-Interrupt Control Register

This block is one byte-wide register of a serial communications interface that carries either 8-bit or 9-bit characters. It serves three parties. The CPU reads and writes it through a small address-decoded port. The receiver pulses a load strobe with the received character and the block keeps the character's extra bit. The transmitter pulses its own load strobe, and the block passes its stored outgoing ninth bit to the shift register on that same edge.

The register also holds four enable bits, one for each receiver error flag: overrun, noise, framing and parity. Each enabled flag that is high contributes to a single registered error-interrupt request. The receiver and transmitter ninth bits are not touched by reset. The enables and the interrupt request are cleared by reset, so no request can be raised until software sets an enable.

Top module: `nberr_reg`

## Requirements
- R1: A read at address 0x3A returns bit 7 = received ninth bit, bit 6 = transmit ninth bit, bits 5:4 = 0, bit 3 = overrun enable, bit 2 = noise enable, bit 1 = framing enable and bit 0 = parity enable. A read at any other address returns 0x00. The read data is combinational from the address.
- R2: A write to 0x3A updates bit 6 and bits 3:0 at the next clock edge. The written bits 7, 5 and 4 are ignored. A write to any other address changes nothing.
- R3: On a receive load with the 9-bit mode input at 1, the received ninth bit takes data bit 8 at that edge.
- R4: On a receive load with the 9-bit mode input at 0, the received ninth bit takes data bit 7 at that edge.
- R5: Without a receive load the received ninth bit holds its value, including across CPU writes and changes of the receive data.
- R6: On a transmit load, the output to the shifter takes the transmit ninth bit held before that edge, even when a CPU write to it lands in the same cycle. Without a transmit load the output holds its value.
- R7: The error request equals the OR over the four flags, with flag bit 3 = overrun, 2 = noise, 1 = framing and 0 = parity, each ANDed with its enable, as sampled at the previous clock edge.
- R8: Reset clears all four enables and the error request. Reset leaves the received ninth bit, the transmit ninth bit and the shifter's ninth-bit output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 8 | CPU register address |
| cpuWr | input | 1 | CPU write strobe |
| cpuWrData | input | 8 | CPU write data |
| cpuRdData | output | 8 | CPU read data |
| rxLoad | input | 1 | Receiver has a complete character |
| rxChar | input | 9 | Received character, bit 8 = ninth bit |
| rxNineBit | input | 1 | 1 = 9-bit characters, 0 = 8-bit characters |
| errFlags | input | 4 | Overrun, noise, framing, parity (bit 3 down to 0) |
| txLoad | input | 1 | Transmit shifter is loading a byte |
| txNinth | output | 1 | Ninth bit handed to the transmit shifter |
| errIrq | output | 1 | Registered error interrupt request |

## Verification
The properties assume that the receive data and the mode input are stable at the edge where the receive load strobe is high. They also assume that the error flags are plain levels that change only between clock edges. The bench drives every input on the falling edge, so each property sees settled values at the rising edge. Reset is always released on a falling edge, away from any capture, so the check that the enables come out of reset cleared sees a clean transition. The ninth bits are left untouched by reset and so power up unknown. The bench's model marks them as unknown and does not compare them until a load or a write has set them.

// File: rtl/nberr_pkg.sv
package nberr_pkg;
  localparam int RX9_POS = 7;
  localparam int TX9_POS = 6;

  typedef struct packed {
    logic regSel;
    logic regWr;
    logic rxCap;
    logic rxWide;
    logic txCap;
  } nberr_strobe_t;
endpackage

// File: rtl/nberr_ctrl.sv
module nberr_ctrl
  import nberr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h3A
) (
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWr,
  input  logic              rxLoad,
  input  logic              rxNineBit,
  input  logic              txLoad,
  output nberr_strobe_t     stb
);
  logic addrHit;

  assign addrHit = (cpuAddr == REG_ADDR);

  always_comb begin
    stb        = '0;
    stb.regSel = addrHit;
    stb.regWr  = addrHit & cpuWr;
    stb.rxCap  = rxLoad;
    stb.rxWide = rxNineBit;
    stb.txCap  = txLoad;
  end
endmodule

// File: rtl/nberr_datapath.sv
module nberr_datapath
  import nberr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  nberr_strobe_t     stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W:0]   rxChar,
  input  logic [ERR_W-1:0]  errFlags,
  output logic [DATA_W-1:0] rdData,
  output logic              txNinth,
  output logic              errIrq
);
  localparam int PAD_W = DATA_W - 2 - ERR_W;

  logic             rxNinthReg;
  logic             txNinthReg;
  logic             txShift9;
  logic [ERR_W-1:0] errEn;
  logic [ERR_W-1:0] gated;

  // Ninth bits: no reset by design
  always_ff @(posedge clk) begin
    if (stb.rxCap) rxNinthReg <= stb.rxWide ? rxChar[DATA_W] : rxChar[DATA_W-1];
  end

  always_ff @(posedge clk) begin
    if (stb.regWr) txNinthReg <= wrData[TX9_POS];
  end

  always_ff @(posedge clk) begin
    if (stb.txCap) txShift9 <= txNinthReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          errEn <= '0;
    else if (stb.regWr) errEn <= wrData[ERR_W-1:0];
  end

  for (genvar gi = 0; gi < ERR_W; gi++) begin : g_gate
    assign gated[gi] = errFlags[gi] & errEn[gi];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errIrq <= 1'b0;
    else       errIrq <= |gated;
  end

  always_comb begin
    rdData = '0;
    if (stb.regSel) rdData = {rxNinthReg, txNinthReg, {PAD_W{1'b0}}, errEn};
  end

  assign txNinth = txShift9;

  // R3: 9-bit capture
  p_rx_wide_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.rxCap && stb.rxWide |=> rxNinthReg == $past(rxChar[DATA_W]));
  // R4: 8-bit mirror of bit 7
  p_rx_narrow_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.rxCap && !stb.rxWide |=> rxNinthReg == $past(rxChar[DATA_W-1]));
  // R5: hold without a load
  p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rxCap |=> $stable(rxNinthReg));
  // R6: handoff and hold
  p_tx_take_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.txCap |=> txShift9 == $past(txNinthReg));
  p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !stb.txCap |=> $stable(txShift9));
  // R7: a request needs a flag one cycle earlier
  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    errIrq |-> $past(|errFlags));
  // R8: enables and request come out of reset cleared
  p_reset_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (errEn == '0) && !errIrq);
endmodule

// File: rtl/nberr_reg.sv
module nberr_reg
  import nberr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int ERR_W  = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h3A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWr,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic [DATA_W-1:0] cpuRdData,
  input  logic              rxLoad,
  input  logic [DATA_W:0]   rxChar,
  input  logic              rxNineBit,
  input  logic [ERR_W-1:0]  errFlags,
  input  logic              txLoad,
  output logic              txNinth,
  output logic              errIrq
);
  nberr_strobe_t stb;

  nberr_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_ctrl (
    .cpuAddr(cpuAddr), .cpuWr(cpuWr), .rxLoad(rxLoad),
    .rxNineBit(rxNineBit), .txLoad(txLoad), .stb(stb)
  );

  nberr_datapath #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(cpuWrData),
    .rxChar(rxChar), .errFlags(errFlags), .rdData(cpuRdData),
    .txNinth(txNinth), .errIrq(errIrq)
  );
endmodule

// File: tb/nberr_reg_bench.sv
module nberr_reg_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] REG_AT = 8'h3A;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] cpuAddr = REG_AT;
  logic       cpuWr = 1'b0;
  logic [7:0] cpuWrData = '0;
  logic [7:0] cpuRdData;
  logic       rxLoad = 1'b0;
  logic [8:0] rxChar = '0;
  logic       rxNineBit = 1'b0;
  logic [3:0] errFlags = '0;
  logic       txLoad = 1'b0;
  logic       txNinth;
  logic       errIrq;

  nberr_reg u_nberr_reg (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWr(cpuWr),
    .cpuWrData(cpuWrData), .cpuRdData(cpuRdData), .rxLoad(rxLoad),
    .rxChar(rxChar), .rxNineBit(rxNineBit), .errFlags(errFlags),
    .txLoad(txLoad), .txNinth(txNinth), .errIrq(errIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  string curReq = "R8";
  bit done = 0;

  // reference model state
  bit mR8, mR8Known, mT8, mT8Known, mTx, mTxKnown, mIrq;
  bit [3:0] mEn;

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", curReq, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit nR8, nT8, nTx, nIrq;
    bit [3:0] nEn;
    bit [7:0] expRd, mask;
    nR8 = mR8; nT8 = mT8; nTx = mTx; nEn = mEn; nIrq = mIrq;
    if (!rstN) begin
      nEn = 0; nIrq = 0;
    end else begin
      nIrq = |(errFlags & mEn);
      if (txLoad) begin nTx = mT8; mTxKnown = mT8Known; end
      if (cpuWr && cpuAddr == REG_AT) begin
        nT8 = cpuWrData[6]; nEn = cpuWrData[3:0]; mT8Known = 1;
      end
      if (rxLoad) begin
        nR8 = rxNineBit ? rxChar[8] : rxChar[7]; mR8Known = 1;
      end
    end
    mR8 = nR8; mT8 = nT8; mTx = nTx; mEn = nEn; mIrq = nIrq;
    #1;
    if (!done) begin
      expRd = (cpuAddr == REG_AT) ? {mR8, mT8, 2'b00, mEn} : 8'h00;
      mask = {mR8Known ? 1'b1 : 1'b0, mT8Known ? 1'b1 : 1'b0, 6'h3F};
      if (cpuAddr != REG_AT) mask = 8'hFF;
      check("rdData", int'(cpuRdData & mask), int'(expRd & mask));
      check("errIrq", int'(errIrq), int'(mIrq));
      if (mTxKnown) check("txNinth", int'(txNinth), int'(mTx));
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cpuWrite(logic [7:0] a, logic [7:0] d);
    cpuAddr = a; cpuWr = 1; cpuWrData = d;
    tick();
    cpuWr = 0; cpuAddr = REG_AT;
  endtask

  task automatic rxPut(logic mode, logic [8:0] c);
    rxNineBit = mode; rxChar = c; rxLoad = 1;
    tick();
    rxLoad = 0;
  endtask

  initial begin
    tick(3);
    rstN = 1;
    tick(2);
    // R1 / R2: register layout and writes
    curReq = "R2";
    cpuWrite(REG_AT, 8'hFF);
    tick();
    curReq = "R1";
    cpuAddr = 8'h3B; tick(2);
    cpuAddr = 8'h00; tick(); cpuAddr = REG_AT; tick();
    curReq = "R2";
    cpuWrite(8'h3B, 8'h00);
    tick();
    cpuWrite(REG_AT, 8'hB5);
    tick();
    cpuWrite(REG_AT, 8'h4A);
    tick();
    // R3: 9-bit capture
    curReq = "R3";
    rxPut(1, 9'h100); tick();
    rxPut(1, 9'h0FF); tick();
    rxPut(1, 9'h1FF); tick();
    // R4: 8-bit mirror of bit 7
    curReq = "R4";
    rxPut(0, 9'h07F); tick();
    rxPut(0, 9'h080); tick();
    rxPut(0, 9'h17F); tick();
    // R5: hold
    curReq = "R5";
    rxPut(1, 9'h100);
    rxChar = 9'h000; rxNineBit = 0; tick(2);
    cpuWrite(REG_AT, 8'h00); tick();
    rxChar = 9'h0FF; tick(2);
    // R6: handoff to shifter
    curReq = "R6";
    cpuWrite(REG_AT, 8'h40);
    txLoad = 1; tick(); txLoad = 0; tick(2);
    cpuAddr = REG_AT; cpuWr = 1; cpuWrData = 8'h00; txLoad = 1;
    tick();
    cpuWr = 0; txLoad = 0; tick(2);
    txLoad = 1; tick(); txLoad = 0;
    cpuWrite(REG_AT, 8'h40); tick(2);
    // R7: every enable against every flag pattern
    curReq = "R7";
    for (int e = 0; e < 16; e++) begin
      cpuWrite(REG_AT, 8'(e));
      for (int f = 0; f < 16; f++) begin
        errFlags = 4'(f); tick();
      end
      errFlags = 0; tick();
    end
    // R8: reset with everything set
    curReq = "R8";
    cpuWrite(REG_AT, 8'h4F);
    rxPut(1, 9'h100);
    txLoad = 1; tick(); txLoad = 0;
    errFlags = 4'hF; tick(2);
    rstN = 0; tick(3);
    rstN = 1; tick(3);
    errFlags = 0; tick(2);
    done = 1;
    tick();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL %s watchdog actual=1 expected=0", curReq);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule